// File: doc/BRIEF.md
# Text Cursor Write Controller

This block turns two independent character sources into one stream of writes to a text-screen character memory. It tracks an invisible cursor on an 80-column by 30-row grid. Each time a character is accepted, the block raises a write strobe with the cursor position as the memory address, then moves the cursor one cell forward in reading order.

One source is a debounced push-button paired with a set of switches that hold the character code. The button is level-sensitive at the input, so the block contains its own one-shot detector, and a held button yields one write only. The other source is a serial receiver's byte-valid pulse with the low seven bits of the received byte. When both sources fire in the same cycle, the serial byte is written and the button event is discarded.

The write strobe, address and character are combinational from the inputs and the cursor state, so a write appears in the same cycle as its trigger. The cursor register moves on the clock edge that ends that cycle.

Top module: `text_cursor_writer`

## Requirements
- R1: `wr_en` is high in a cycle exactly when `rst` is low and either `rx_valid` is high, or `btn_level` is high while it was low in the previous cycle. Otherwise `wr_en` is low.
- R2: Holding `btn_level` high for many cycles produces exactly one write. A further button write needs the level to go low and then high again.
- R3: During a write, `wr_char` equals `rx_char` when `rx_valid` is high, and equals `sw_char` when the write comes from the button.
- R4: `wr_addr` always shows the current cursor, with the row number in bits 11:7 and the column number in bits 6:0.
- R5: After a write with the column below 79, the column increases by one and the row is kept.
- R6: After a write at column 79 with the row below 29, the column becomes 0 and the row increases by one.
- R7: After a write at column 79, row 29, the cursor returns to column 0, row 0.
- R8: In a cycle with no write, the cursor, and so `wr_addr`, stays unchanged.
- R9: When a button edge and `rx_valid` occur in the same cycle, one write is made with `rx_char`. The button event is dropped and does not cause a write in a later cycle.
- R10: While `rst` is high at a clock edge, the cursor goes to (0,0) and the button detector's stored level goes low. While `rst` is high, `wr_en` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| btn_level | input | 1 | Debounced button level |
| sw_char | input | 7 | Character code used for button writes |
| rx_valid | input | 1 | One-cycle pulse marking a received byte |
| rx_char | input | 7 | Low seven bits of the received byte |
| wr_en | output | 1 | Character memory write strobe |
| wr_addr | output | 12 | Write address, {row[4:0], col[6:0]} |
| wr_char | output | 7 | Character value to store |

## Verification
The strobe, address and character respond to the inputs with zero cycles of latency. The cursor, and so the next address, changes one clock edge after an accepted write. The bench therefore drives inputs on the falling edge, checks the strobe, address and character shortly after, and only then lets the rising edge move its own cursor model. Each check compares against the model as it stood before that edge. The bench covers a held button, a button edge that coincides with a received byte, the row change at column 79, and the full-screen wrap after 2400 writes, and it mixes these with seeded random traffic.

// File: rtl/cursor_pkg.sv
package cursor_pkg;

    localparam int GRID_COLS = 80;
    localparam int GRID_ROWS = 30;
    localparam int COL_W     = $clog2(GRID_COLS);
    localparam int ROW_W     = $clog2(GRID_ROWS);
    localparam int ADDR_W    = ROW_W + COL_W;
    localparam int CHAR_W    = 7;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } cursor_t;

    typedef enum logic [1:0] {
        SRC_IDLE   = 2'd0,
        SRC_UART   = 2'd1,
        SRC_BUTTON = 2'd2
    } wr_src_e;

    function automatic cursor_t cursor_advance(input cursor_t cur,
                                               input int last_col,
                                               input int last_row);
        cursor_t nxt;
        nxt = cur;
        if (cur.col != COL_W'(last_col)) begin
            nxt.col = cur.col + 1'b1;
        end else if (cur.row != ROW_W'(last_row)) begin
            nxt.col = '0;
            nxt.row = cur.row + 1'b1;
        end else begin
            nxt.col = '0;
            nxt.row = '0;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/rise_detect.sv
module rise_detect (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic pulse
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b0;
        else     level_q <= level;
    end

    assign pulse = level & ~level_q;

    // R2: a pulse never lasts two cycles while the level is held
    a_r2_one_shot: assert property (@(posedge clk) disable iff (rst)
        (pulse && level) |=> !pulse);

endmodule

// File: rtl/source_select.sv
module source_select
    import cursor_pkg::*;
#(
    parameter int DATA_W = CHAR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              uart_valid,
    input  logic [DATA_W-1:0] uart_data,
    input  logic              btn_pulse,
    input  logic [DATA_W-1:0] btn_data,
    output wr_src_e           src,
    output logic [DATA_W-1:0] data
);
    always_comb begin
        src = SRC_IDLE;
        if (!rst) begin
            if (uart_valid)     src = SRC_UART;
            else if (btn_pulse) src = SRC_BUTTON;
        end
    end

    always_comb begin
        unique case (src)
            SRC_UART:   data = uart_data;
            SRC_BUTTON: data = btn_data;
            default:    data = uart_data;
        endcase
    end

    // R9: the serial byte wins a collision
    a_r9_uart_wins: assert property (@(posedge clk) disable iff (rst)
        (uart_valid && btn_pulse) |-> (src == SRC_UART && data == uart_data));

    // R3: a button-only request carries the switch value
    a_r3_button_char: assert property (@(posedge clk) disable iff (rst)
        (!uart_valid && btn_pulse) |-> (src == SRC_BUTTON && data == btn_data));

    // R10: nothing is selected while reset is held
    a_r10_idle_in_reset: assert property (@(posedge clk)
        rst |-> src == SRC_IDLE);

endmodule

// File: rtl/cursor_track.sv
module cursor_track
    import cursor_pkg::*;
#(
    parameter int NUM_COLS = GRID_COLS,
    parameter int NUM_ROWS = GRID_ROWS
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    advance,
    output cursor_t cur
);
    localparam int LAST_COL = NUM_COLS - 1;
    localparam int LAST_ROW = NUM_ROWS - 1;

    always_ff @(posedge clk) begin
        if (rst)          cur <= '0;
        else if (advance) cur <= cursor_advance(cur, LAST_COL, LAST_ROW);
    end

    // R4: the cursor never leaves the visible grid
    a_r4_in_grid: assert property (@(posedge clk) disable iff (rst)
        (cur.col <= COL_W'(LAST_COL)) && (cur.row <= ROW_W'(LAST_ROW)));

    // R5: a mid-row step
    a_r5_col_step: assert property (@(posedge clk) disable iff (rst)
        (advance && cur.col < COL_W'(LAST_COL)) |=>
        (cur.col == $past(cur.col) + 1'b1) && (cur.row == $past(cur.row)));

    // R6: end of a row that is not the last
    a_r6_next_row: assert property (@(posedge clk) disable iff (rst)
        (advance && cur.col == COL_W'(LAST_COL) && cur.row < ROW_W'(LAST_ROW)) |=>
        (cur.col == '0) && (cur.row == $past(cur.row) + 1'b1));

    // R7: end of the last row
    a_r7_home: assert property (@(posedge clk) disable iff (rst)
        (advance && cur.col == COL_W'(LAST_COL) && cur.row == ROW_W'(LAST_ROW)) |=>
        (cur == '0));

    // R8: no write, no movement
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(cur));

endmodule

// File: rtl/text_cursor_writer.sv
module text_cursor_writer
    import cursor_pkg::*;
#(
    parameter int NUM_COLS = GRID_COLS,
    parameter int NUM_ROWS = GRID_ROWS,
    parameter int DATA_W   = CHAR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              btn_level,
    input  logic [DATA_W-1:0] sw_char,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_char,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_char
);
    logic    btn_pulse;
    wr_src_e src;
    cursor_t cur;

    rise_detect u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (btn_level),
        .pulse (btn_pulse)
    );

    source_select #(.DATA_W(DATA_W)) u_sel (
        .clk        (clk),
        .rst        (rst),
        .uart_valid (rx_valid),
        .uart_data  (rx_char),
        .btn_pulse  (btn_pulse),
        .btn_data   (sw_char),
        .src        (src),
        .data       (wr_char)
    );

    assign wr_en = (src != SRC_IDLE);

    cursor_track #(.NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS)) u_cur (
        .clk     (clk),
        .rst     (rst),
        .advance (wr_en),
        .cur     (cur)
    );

    assign wr_addr = cur;

    // R1: every received byte is written
    a_r1_uart_writes: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> wr_en);

    // R1: no trigger, no strobe
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
        (!rx_valid && !btn_level) |-> !wr_en);

endmodule

// File: tb/sim_text_cursor_writer.sv
module sim_text_cursor_writer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       btn_level = 1'b0;
    logic [6:0] sw_char = '0;
    logic       rx_valid = 1'b0;
    logic [6:0] rx_char = '0;
    logic       wr_en;
    logic [11:0] wr_addr;
    logic [6:0] wr_char;

    int n_checks = 0;
    int n_fail = 0;
    int n_writes = 0;
    bit done = 1'b0;

    int m_row = 0;
    int m_col = 0;
    bit m_prev = 1'b0;

    always #2 clk = ~clk;

    text_cursor_writer u0 (
        .clk       (clk),
        .rst       (rst),
        .btn_level (btn_level),
        .sw_char   (sw_char),
        .rx_valid  (rx_valid),
        .rx_char   (rx_char),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_char   (wr_char)
    );

    function automatic int pack_addr(input int row, input int col);
        return row * 128 + col;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_advance();
        if (m_col < 79) m_col++;
        else if (m_row < 29) begin m_col = 0; m_row++; end
        else begin m_col = 0; m_row = 0; end
    endtask

    task automatic step(input bit r, input bit b, input bit rv,
                        input logic [6:0] rc, input logic [6:0] s);
        bit exp_we;
        @(negedge clk);
        rst = r; btn_level = b; rx_valid = rv; rx_char = rc; sw_char = s;
        #1;
        exp_we = !r && (rv || (b && !m_prev));
        if (r) chk("R10 strobe low in reset", int'(wr_en), 0);
        else   chk("R1 write strobe", int'(wr_en), int'(exp_we));
        chk("R4 R8 address", int'(wr_addr), pack_addr(m_row, m_col));
        if (exp_we) chk("R3 character", int'(wr_char), rv ? int'(rc) : int'(s));
        if (wr_en) n_writes++;
        @(posedge clk);
        if (r) begin
            m_row = 0; m_col = 0; m_prev = 1'b0;
        end else begin
            if (exp_we) model_advance();
            m_prev = b;
        end
    endtask

    task automatic uart_write(input logic [6:0] c);
        step(1'b0, 1'b0, 1'b1, c, 7'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int w0;
        void'($urandom(32'd12345));

        // R10: reset with a pending byte writes nothing, cursor at home
        step(1'b1, 1'b0, 1'b1, 7'h41, 7'h00);
        step(1'b1, 1'b1, 1'b1, 7'h42, 7'h00);
        #1 chk("R10 reset cursor", int'(wr_addr), 0);

        // R2: held button gives one write
        w0 = n_writes;
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'b0, 7'h00, 7'h53);
        chk("R2 one write per press", n_writes - w0, 1);
        step(1'b0, 1'b0, 1'b0, 7'h00, 7'h53);
        w0 = n_writes;
        step(1'b0, 1'b1, 1'b0, 7'h00, 7'h54);
        chk("R2 second press", n_writes - w0, 1);
        step(1'b0, 1'b0, 1'b0, 7'h00, 7'h00);

        // R9: collision, byte wins, button dropped
        w0 = n_writes;
        step(1'b0, 1'b1, 1'b1, 7'h41, 7'h53);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0, 7'h00, 7'h53);
        chk("R9 single write on collision", n_writes - w0, 1);
        #1 chk("R9 cursor after collision", int'(wr_addr), pack_addr(0, 3));
        step(1'b0, 1'b0, 1'b0, 7'h00, 7'h00);

        // R5 and R6: walk to column 79 of row 0
        while (m_col != 79) uart_write(7'h2E);
        #1 chk("R5 reached column 79", int'(wr_addr), pack_addr(0, 79));
        uart_write(7'h21);
        #1 chk("R6 row advance", int'(wr_addr), pack_addr(1, 0));
        uart_write(7'h22);
        #1 chk("R5 column step", int'(wr_addr), pack_addr(1, 1));

        // R8: idle cycles keep the cursor
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b0, 7'h7F, 7'h7F);
        #1 chk("R8 idle hold", int'(wr_addr), pack_addr(1, 1));

        // R7: full screen wrap
        step(1'b1, 1'b0, 1'b0, 7'h00, 7'h00);
        for (int i = 0; i < 2399; i++) uart_write(7'(i));
        #1 chk("R7 last cell", int'(wr_addr), pack_addr(29, 79));
        uart_write(7'h5A);
        #1 chk("R7 home after wrap", int'(wr_addr), 0);

        // R10: reset with button held re-arms the detector
        step(1'b0, 1'b1, 1'b0, 7'h00, 7'h30);
        step(1'b1, 1'b1, 1'b0, 7'h00, 7'h31);
        w0 = n_writes;
        step(1'b0, 1'b1, 1'b0, 7'h00, 7'h32);
        chk("R10 detector cleared by reset", n_writes - w0, 1);

        // mixed random traffic
        for (int i = 0; i < 4000; i++) begin
            bit r, b, rv;
            r  = ($urandom % 200) == 0;
            b  = ($urandom % 3) == 0;
            rv = ($urandom % 4) == 0;
            step(r, b, rv, 7'($urandom), 7'($urandom));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule